// File: doc/BRIEF.md
# Multiplexed Bus Register Port

This block is the host-facing register access port of a small peripheral that sits on an 8-bit shared address/data bus driven with separate read and write strobes. The host first places a register address on the bus and pulses the address strobe. On the falling edge of that strobe the block latches the address, and it holds that address until the next such edge. The host then either lowers the read strobe, which makes the block drive the addressed register's contents onto the bus, or pulses the write strobe, whose rising edge commits the bus value to the addressed register.

All bus pins are asynchronous to the peripheral. They pass through a synchronizer and are edge-detected on the internal clock. Toward the internal logic the block offers a read address with combinational read data, a one-cycle read-event pulse, and a one-cycle write command with its own address and data. Toward the pins it offers an output value and an output-enable for the bus pads. The address capture ignores chip select. Reads and writes need chip select to be active.

Top module: `muxbus_port`

## Requirements
- R1: On a falling edge of `as_i`, `reg_addr_o` takes the value of `bus_i` at that edge, three clock edges after the input change (two synchronizer stages plus one register). It keeps that value until the next falling edge of `as_i`.
- R2: Address latching takes place whether `cs_ni` is high or low.
- R3: `bus_oe_o` is 1 while the synchronized `cs_ni` and `ds_ni` are both low, and `bus_o` then equals `reg_rdata_i`. Otherwise `bus_oe_o` is 0 and `bus_o` is 0.
- R4: Each falling edge of `ds_ni` that occurs while `cs_ni` is low produces exactly one single-cycle `reg_re_o` pulse. A falling edge of `ds_ni` while `cs_ni` is high produces none.
- R5: A rising edge of `wr_ni` while `cs_ni` is low produces exactly one single-cycle `reg_we_o` pulse. During that pulse `reg_waddr_o` is the latched address and `reg_wdata_o` is the bus value at the edge.
- R6: A rising edge of `wr_ni` while `cs_ni` is high is ignored: no write pulse occurs, and the register file keeps its contents.
- R7: While `rst_ni` is low, `bus_oe_o`, `reg_we_o` and `reg_re_o` stay 0 and `reg_addr_o` stays 0, whatever the strobes do.
- R8: When a falling edge of `as_i` and a rising edge of `wr_ni` fall in the same cycle, the write goes to the previously latched address. The new address is latched in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Internal clock |
| rst_ni | input | 1 | Active-low asynchronous reset; blocks all access while low |
| cs_ni | input | 1 | Chip select, active low |
| as_i | input | 1 | Address strobe; the falling edge latches the address |
| ds_ni | input | 1 | Read strobe, active low |
| wr_ni | input | 1 | Write strobe, active low; the rising edge commits the data |
| bus_i | input | 8 | Shared bus input value |
| bus_o | output | 8 | Bus output value, 0 when not driving |
| bus_oe_o | output | 1 | Bus pad output enable |
| reg_addr_o | output | 8 | Latched register address, used for reads |
| reg_rdata_i | input | 8 | Register file read data at `reg_addr_o` |
| reg_re_o | output | 1 | One-cycle read event |
| reg_we_o | output | 1 | One-cycle write command |
| reg_waddr_o | output | 8 | Write address |
| reg_wdata_o | output | 8 | Write data |

## Verification
The address capture and the write commit can land in the same cycle. In that cycle the write must use the old address while the latch moves to the new one. The bench provokes this by holding the write strobe low, raising the address strobe, and then releasing both on the same clock phase, with one bus value serving as both the new address and the write data. The scoreboard expects a write of that value to the previously latched address, and a port check then confirms that the latch shows the new value.

// File: rtl/muxbus_pkg.sv
package muxbus_pkg;
  typedef struct packed {
    logic as_fall;
    logic ds_fall;
    logic wr_rise;
    logic ds_low;
    logic cs_act;
  } strobe_ev_t;
endpackage

// File: rtl/mb_sync.sv
module mb_sync #(
  parameter int          STAGES = 2,
  parameter int          W      = 1,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] chain [STAGES];

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) chain[s] <= RST_VAL;
      else if (s == 0) chain[s] <= d_i;
      else chain[s] <= chain[(s == 0) ? 0 : s-1];
    end
  end

  assign q_o = chain[STAGES-1];
endmodule

// File: rtl/mb_edge.sv
module mb_edge
  import muxbus_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       as_s_i,
  input  logic       ds_ns_i,
  input  logic       wr_ns_i,
  input  logic       cs_ns_i,
  output strobe_ev_t ev_o
);
  logic as_q, ds_nq, wr_nq;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      as_q  <= 1'b0;
      ds_nq <= 1'b1;
      wr_nq <= 1'b1;
    end else begin
      as_q  <= as_s_i;
      ds_nq <= ds_ns_i;
      wr_nq <= wr_ns_i;
    end
  end

  always_comb begin
    ev_o.as_fall = as_q & ~as_s_i;
    ev_o.ds_fall = ds_nq & ~ds_ns_i;
    ev_o.wr_rise = ~wr_nq & wr_ns_i;
    ev_o.ds_low  = ~ds_ns_i;
    ev_o.cs_act  = ~cs_ns_i;
  end
endmodule

// File: rtl/mb_addr_latch.sv
module mb_addr_latch #(
  parameter int AW = 8
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          cap_i,
  input  logic [AW-1:0] bus_i,
  output logic [AW-1:0] addr_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    addr_o <= '0;
    else if (cap_i) addr_o <= bus_i;
  end
endmodule

// File: rtl/mb_access.sv
module mb_access
  import muxbus_pkg::*;
#(
  parameter int DW = 8
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  strobe_ev_t    ev_i,
  input  logic [DW-1:0] addr_i,
  input  logic [DW-1:0] bus_i,
  input  logic [DW-1:0] rdata_i,
  output logic          oe_o,
  output logic [DW-1:0] bus_o,
  output logic          re_o,
  output logic          we_o,
  output logic [DW-1:0] waddr_o,
  output logic [DW-1:0] wdata_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      oe_o    <= 1'b0;
      re_o    <= 1'b0;
      we_o    <= 1'b0;
      waddr_o <= '0;
      wdata_o <= '0;
    end else begin
      oe_o <= ev_i.cs_act & ev_i.ds_low;
      re_o <= ev_i.cs_act & ev_i.ds_fall;
      we_o <= ev_i.cs_act & ev_i.wr_rise;
      if (ev_i.cs_act && ev_i.wr_rise) begin
        // addr_i is the pre-update value, so a coincident address strobe does not redirect the write
        waddr_o <= addr_i;
        wdata_o <= bus_i;
      end
    end
  end

  assign bus_o = oe_o ? rdata_i : '0;
endmodule

// File: rtl/muxbus_port.sv
module muxbus_port
  import muxbus_pkg::*;
#(
  parameter int DW          = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          cs_ni,
  input  logic          as_i,
  input  logic          ds_ni,
  input  logic          wr_ni,
  input  logic [DW-1:0] bus_i,
  output logic [DW-1:0] bus_o,
  output logic          bus_oe_o,
  output logic [DW-1:0] reg_addr_o,
  input  logic [DW-1:0] reg_rdata_i,
  output logic          reg_re_o,
  output logic          reg_we_o,
  output logic [DW-1:0] reg_waddr_o,
  output logic [DW-1:0] reg_wdata_o
);
  localparam int NSTB = 4;
  localparam logic [NSTB-1:0] STB_IDLE = 4'b1110; // cs_n, ds_n, wr_n, as

  logic [NSTB-1:0] stb_s;
  logic [DW-1:0]   bus_s;
  strobe_ev_t      ev;

  mb_sync #(.STAGES(SYNC_STAGES), .W(NSTB), .RST_VAL(STB_IDLE)) u_sync_stb (
    .clk_i, .rst_ni,
    .d_i ({cs_ni, ds_ni, wr_ni, as_i}),
    .q_o (stb_s)
  );

  // bus delayed by the same depth so data aligns with the detected edge
  mb_sync #(.STAGES(SYNC_STAGES), .W(DW), .RST_VAL('0)) u_sync_bus (
    .clk_i, .rst_ni,
    .d_i (bus_i),
    .q_o (bus_s)
  );

  mb_edge u_edge (
    .clk_i, .rst_ni,
    .as_s_i  (stb_s[0]),
    .wr_ns_i (stb_s[1]),
    .ds_ns_i (stb_s[2]),
    .cs_ns_i (stb_s[3]),
    .ev_o    (ev)
  );

  mb_addr_latch #(.AW(DW)) u_addr (
    .clk_i, .rst_ni,
    .cap_i  (ev.as_fall),
    .bus_i  (bus_s),
    .addr_o (reg_addr_o)
  );

  mb_access #(.DW(DW)) u_acc (
    .clk_i, .rst_ni,
    .ev_i    (ev),
    .addr_i  (reg_addr_o),
    .bus_i   (bus_s),
    .rdata_i (reg_rdata_i),
    .oe_o    (bus_oe_o),
    .bus_o   (bus_o),
    .re_o    (reg_re_o),
    .we_o    (reg_we_o),
    .waddr_o (reg_waddr_o),
    .wdata_o (reg_wdata_o)
  );
endmodule

// File: rtl/muxbus_port_chk.sv
module muxbus_port_chk #(
  parameter int DW = 8
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          as_fall_i,
  input logic          bus_oe_o,
  input logic [DW-1:0] bus_o,
  input logic [DW-1:0] reg_addr_o,
  input logic          reg_re_o,
  input logic          reg_we_o
);
  a_r1_addr_only_on_strobe: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(reg_addr_o) |-> $past(as_fall_i));

  a_r3_idle_bus_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !bus_oe_o |-> bus_o == '0);

  a_r4_re_single: assert property (@(posedge clk_i) disable iff (!rst_ni)
    reg_re_o |=> !reg_re_o);

  a_r4_re_with_drive: assert property (@(posedge clk_i) disable iff (!rst_ni)
    reg_re_o |-> bus_oe_o);

  a_r5_we_single: assert property (@(posedge clk_i) disable iff (!rst_ni)
    reg_we_o |=> !reg_we_o);

  // R7: reset forces every access output inactive
  always_comb begin
    if (!rst_ni) begin
      a_r7_reset_quiet: assert (!bus_oe_o && !reg_we_o && !reg_re_o);
    end
  end
endmodule

bind muxbus_port muxbus_port_chk #(.DW(DW)) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .as_fall_i  (ev.as_fall),
  .bus_oe_o   (bus_oe_o),
  .bus_o      (bus_o),
  .reg_addr_o (reg_addr_o),
  .reg_re_o   (reg_re_o),
  .reg_we_o   (reg_we_o)
);

// File: tb/muxbus_port_tb.sv
module muxbus_port_tb;
  localparam int DW = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cs_n = 1'b1, as = 1'b0, ds_n = 1'b1, wr_n = 1'b1;
  logic [DW-1:0] bus_in = '0;
  logic [DW-1:0] bus_out, addr, rdata, waddr, wdata;
  logic oe, re, we;

  always #10 clk = ~clk;

  muxbus_port u_dut (
    .clk_i(clk), .rst_ni(rst_n), .cs_ni(cs_n), .as_i(as), .ds_ni(ds_n),
    .wr_ni(wr_n), .bus_i(bus_in), .bus_o(bus_out), .bus_oe_o(oe),
    .reg_addr_o(addr), .reg_rdata_i(rdata), .reg_re_o(re),
    .reg_we_o(we), .reg_waddr_o(waddr), .reg_wdata_o(wdata)
  );

  logic [DW-1:0] file_q [256];
  logic [DW-1:0] exp_mem [256];
  assign rdata = file_q[addr];

  initial begin
    for (int i = 0; i < 256; i++) begin
      file_q[i]  = DW'(i) ^ 8'hC3;
      exp_mem[i] = DW'(i) ^ 8'hC3;
    end
  end

  always @(posedge clk) if (we) file_q[waddr] <= wdata;

  int n_chk = 0, n_fail = 0, re_cnt = 0;
  logic [DW-1:0] cur_addr = '0;
  logic [2*DW-1:0] sb [$];

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // monitor: pops expected writes
  always @(negedge clk) begin
    if (we) begin
      if (sb.size() == 0) check(1'b0, "R6 unexpected write", {waddr, wdata}, 0);
      else begin
        logic [2*DW-1:0] e;
        e = sb.pop_front();
        check({waddr, wdata} == e, "R5/R8 write", {waddr, wdata}, e);
      end
    end
    if (re) re_cnt++;
  end

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic put_addr(input logic [DW-1:0] a);
    bus_in = a; as = 1'b1; cyc(3);
    as = 1'b0; cyc(4);
    cur_addr = a;
  endtask

  task automatic put_write(input logic [DW-1:0] d);
    bus_in = d; wr_n = 1'b0; cyc(3);
    if (!cs_n) begin
      sb.push_back({cur_addr, d});
      exp_mem[cur_addr] = d;
    end
    wr_n = 1'b1; cyc(4);
  endtask

  task automatic do_read(input string req);
    int re0;
    re0 = re_cnt;
    ds_n = 1'b0; cyc(4);
    if (!cs_n) begin
      check(oe === 1'b1, req, oe, 1);
      check(bus_out === exp_mem[cur_addr], req, bus_out, exp_mem[cur_addr]);
      check(re_cnt == re0 + 1, "R4 one read pulse", re_cnt - re0, 1);
    end else begin
      check(oe === 1'b0, req, oe, 0);
      check(bus_out === '0, req, bus_out, 0);
      check(re_cnt == re0, "R4 no pulse without select", re_cnt - re0, 0);
    end
    ds_n = 1'b1; cyc(4);
    check(oe === 1'b0, "R3 released", oe, 0);
  endtask

  bit done = 0;
  initial begin
    #(20 * 150000);
    if (!done) begin
      check(1'b0, "watchdog", 0, 1);
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    // R7: held in reset with strobes active
    cyc(2);
    check(oe === 1'b0 && we === 1'b0 && re === 1'b0, "R7 reset outputs", {oe, we, re}, 0);
    check(addr === '0, "R7 reset addr", addr, 0);
    cs_n = 1'b0; ds_n = 1'b0; cyc(4);
    check(oe === 1'b0, "R7 no drive in reset", oe, 0);
    bus_in = 8'h99; as = 1'b1; wr_n = 1'b0; cyc(3);
    as = 1'b0; wr_n = 1'b1; cyc(4);
    check(addr === '0, "R7 no latch in reset", addr, 0);
    check(re_cnt == 0, "R7 no read pulse in reset", re_cnt, 0);
    ds_n = 1'b1; cs_n = 1'b1; cyc(2);
    rst_n = 1'b1; cyc(3);

    // R2: latch with chip select inactive
    put_addr(8'h12);
    check(addr === 8'h12, "R2 latch without select", addr, 8'h12);
    cs_n = 1'b0;
    put_addr(8'h34);
    check(addr === 8'h34, "R1 latch", addr, 8'h34);

    put_write(8'hA5);
    check(sb.size() == 0, "R5 write seen", sb.size(), 0);
    do_read("R3 read back");

    // R6: deselected write ignored
    cs_n = 1'b1;
    put_write(8'h5A);
    do_read("R3 deselected read");
    cs_n = 1'b0;
    do_read("R6 contents kept");
    check(addr === 8'h34, "R1 addr held", addr, 8'h34);

    for (int k = 0; k < 4; k++) begin
      put_addr(8'h80 + DW'(k * 17));
      put_write(8'h0F ^ DW'(k * 37));
      do_read("R3 pattern");
    end
    put_addr(8'hFF);
    do_read("R3 default contents");

    // R8: address strobe fall and write rise in the same cycle
    put_addr(8'h40);
    bus_in = 8'h77; wr_n = 1'b0; as = 1'b1; cyc(3);
    sb.push_back({8'h40, 8'h77});
    exp_mem[8'h40] = 8'h77;
    as = 1'b0; wr_n = 1'b1; cyc(4);
    cur_addr = 8'h77;
    check(sb.size() == 0, "R8 write to old address", sb.size(), 0);
    check(addr === 8'h77, "R8 new address latched", addr, 8'h77);
    do_read("R8 new address read");
    put_addr(8'h40);
    do_read("R8 old address holds data");

    cyc(4);
    check(sb.size() == 0, "R5 scoreboard drained", sb.size(), 0);
    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule